// File: doc/BRIEF.md
# Quadword access pair sequencer

This block takes one decoded 16-byte memory request (plain load, plain store, reserved load or conditional store) and splits it into two 8-byte memory beats. The beats go downstream in increasing address order: base address first, then base + 8. Each beat carries one register of an even/odd register pair. Which register goes with which beat depends on the endianness that was captured when the request was accepted.

Before any beat is issued, the request is checked. A reserved load whose target register equals one of its address registers is illegal. A reserved load, or a little-endian plain load, whose base address is not 16-byte aligned causes an alignment fault. A faulting request produces one output word carrying the fault and no memory beats.

A valid/ready handshake hands beats downstream. Upstream sees a stall for as long as the request is in progress. While the second beat is outstanding, a separate output blocks the acceptance of asynchronous and trace interrupts. A flush in any cycle drops whatever is in progress.

Top module: `qw_pair_seq`

## Requirements
- R1: Every accepted request that does not fault produces exactly two beats, each taken with out_valid and out_ready high, and the block then returns to idle with out_valid low.
- R2: out_repeat is high on both beats of a pair. out_second is high only on the second beat.
- R3: With in_le = 1, the first beat carries the register number with its bit 0 forced to 1 and the second beat carries the number unchanged. With in_le = 0 the first beat carries it unchanged and the second carries it with bit 0 forced to 1.
- R4: The first beat's out_addr is the base address and the second beat's is base + 8.
- R5: Alignment is required when in_kind is 2'b10 (reserved load), or when in_kind is 2'b00 (plain load) with in_le = 1. If it is required and address bits [3:0] are not zero, the block gives one output with out_align_fault = 1, out_repeat = 0 and out_second = 0. Kinds 2'b01 (store) and 2'b11 (conditional store) never fault on alignment.
- R6: A reserved load (in_kind 2'b10) whose in_reg equals in_ra or in_rb gives one output with out_illegal = 1, out_repeat = 0 and out_align_fault = 0. This check takes precedence over the alignment check.
- R7: out_irq_block is high exactly while the second beat is presented.
- R8: in_le is sampled at acceptance. Changing it while the request is in progress does not alter the register numbering of its beats.
- R9: A flush in any cycle clears the request in progress. From the next cycle, out_valid and stall_out are low.
- R10: While out_ready is low, the presented output holds stable and stall_out stays high. No new request is accepted until the last output has been taken.
- R11: After reset, out_valid and stall_out are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Discard any request in progress |
| in_valid | input | 1 | Request present |
| in_kind | input | 2 | 00 load, 01 store, 10 reserved load, 11 conditional store |
| in_addr | input | ADDR_W | Base effective address |
| in_reg | input | REG_W | Target or source register number |
| in_ra | input | REG_W | First address register number |
| in_rb | input | REG_W | Second address register number |
| in_le | input | 1 | 1 = little-endian |
| stall_out | output | 1 | Upstream must hold; no request is accepted |
| out_valid | output | 1 | Beat or fault word presented |
| out_ready | input | 1 | Downstream takes the presented word |
| out_addr | output | ADDR_W | Doubleword address of the beat |
| out_reg | output | REG_W | Register number for the beat |
| out_repeat | output | 1 | Word is one beat of a pair |
| out_second | output | 1 | Word is the second beat |
| out_align_fault | output | 1 | Request misaligned; no beats issued |
| out_illegal | output | 1 | Request is an illegal form; no beats issued |
| out_irq_block | output | 1 | Asynchronous and trace interrupts must not be taken |

## Verification
The hardest case to reach from the ports is a change on upstream inputs while a pair is still in progress. In that case in_le flips and a fresh request is offered while a beat is held back by out_ready. The stimulus does this during a programmed number of back-pressure cycles. It then checks that the second beat still follows the endianness captured at acceptance and that the offered request never appears. A sweep over all four kinds, both endiannesses and every low address nibble covers the fault conditions. A flush is placed on the first beat and again on the second beat.

// File: rtl/qw_pkg.sv
package qw_pkg;

    typedef enum logic [1:0] {
        QK_LOAD       = 2'b00,
        QK_STORE      = 2'b01,
        QK_LOAD_RSV   = 2'b10,
        QK_STORE_COND = 2'b11
    } qk_kind_e;

    typedef enum logic [1:0] {
        QS_IDLE,
        QS_FIRST,
        QS_SECOND,
        QS_FAULT
    } qs_state_e;

    typedef struct packed {
        logic illegal;
        logic misalign;
    } qw_fault_t;

    // Loads that may land a half on a register also used for addressing
    // must not be split across a misaligned boundary.
    function automatic logic needs_quad_align(qk_kind_e kind, logic le);
        return (kind == QK_LOAD_RSV) || (kind == QK_LOAD && le);
    endfunction

endpackage

// File: rtl/qw_check.sv
module qw_check
    import qw_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int REG_W      = 5,
    parameter int QUAD_BYTES = 16
) (
    input  qk_kind_e           kind,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [REG_W-1:0]   tgt,
    input  logic [REG_W-1:0]   ra,
    input  logic [REG_W-1:0]   rb,
    input  logic               le,
    output qw_fault_t          fault
);
    localparam int ALIGN_BITS = $clog2(QUAD_BYTES);

    logic low_bits_set;
    logic overlap;

    always_comb begin
        low_bits_set  = |addr[ALIGN_BITS-1:0];
        overlap       = (tgt == ra) || (tgt == rb);
        fault.illegal = (kind == QK_LOAD_RSV) && overlap;
        fault.misalign = needs_quad_align(kind, le) && low_bits_set;
    end
endmodule

// File: rtl/qw_beat_fmt.sv
module qw_beat_fmt #(
    parameter int ADDR_W   = 16,
    parameter int REG_W    = 5,
    parameter int DW_BYTES = 8
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [REG_W-1:0]  tgt,
    input  logic              le,
    input  logic              second,
    output logic [ADDR_W-1:0] addr,
    output logic [REG_W-1:0]  regnum
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DW_BYTES);

    logic [REG_W-1:0] odd_reg;

    always_comb begin
        odd_reg = tgt | REG_W'(1);
        addr    = second ? base + STEP : base;
        // little-endian: odd first; big-endian: odd second
        regnum  = (second ^ le) ? odd_reg : tgt;
    end
endmodule

// File: rtl/qw_pair_seq.sv
module qw_pair_seq
    import qw_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int REG_W    = 5,
    parameter int DW_BYTES = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              in_valid,
    input  logic [1:0]        in_kind,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [REG_W-1:0]  in_reg,
    input  logic [REG_W-1:0]  in_ra,
    input  logic [REG_W-1:0]  in_rb,
    input  logic              in_le,
    output logic              stall_out,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ADDR_W-1:0] out_addr,
    output logic [REG_W-1:0]  out_reg,
    output logic              out_repeat,
    output logic              out_second,
    output logic              out_align_fault,
    output logic              out_illegal,
    output logic              out_irq_block
);
    localparam int QUAD_BYTES = 2 * DW_BYTES;

    qs_state_e         state_q, state_d;
    logic [ADDR_W-1:0] base_q;
    logic [REG_W-1:0]  tgt_q;
    logic              le_q;
    qw_fault_t         fault_q;
    qw_fault_t         fault_in;
    logic              accept;
    logic              taken;

    qw_check #(
        .ADDR_W     (ADDR_W),
        .REG_W      (REG_W),
        .QUAD_BYTES (QUAD_BYTES)
    ) u_check (
        .kind  (qk_kind_e'(in_kind)),
        .addr  (in_addr),
        .tgt   (in_reg),
        .ra    (in_ra),
        .rb    (in_rb),
        .le    (in_le),
        .fault (fault_in)
    );

    qw_beat_fmt #(
        .ADDR_W   (ADDR_W),
        .REG_W    (REG_W),
        .DW_BYTES (DW_BYTES)
    ) u_fmt (
        .base   (base_q),
        .tgt    (tgt_q),
        .le     (le_q),
        .second (state_q == QS_SECOND),
        .addr   (out_addr),
        .regnum (out_reg)
    );

    always_comb begin
        accept  = (state_q == QS_IDLE) && in_valid && !flush;
        taken   = (state_q != QS_IDLE) && out_ready;
        state_d = state_q;
        if (flush) begin
            state_d = QS_IDLE;
        end else begin
            unique case (state_q)
                QS_IDLE:   if (accept) state_d = (fault_in.illegal || fault_in.misalign)
                                                 ? QS_FAULT : QS_FIRST;
                QS_FIRST:  if (taken) state_d = QS_SECOND;
                QS_SECOND: if (taken) state_d = QS_IDLE;
                QS_FAULT:  if (taken) state_d = QS_IDLE;
                default:   state_d = QS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= QS_IDLE;
            base_q  <= '0;
            tgt_q   <= '0;
            le_q    <= 1'b0;
            fault_q <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                base_q  <= in_addr;
                tgt_q   <= in_reg;
                le_q    <= in_le;
                fault_q <= fault_in;
            end
        end
    end

    always_comb begin
        out_valid       = (state_q != QS_IDLE);
        stall_out       = (state_q != QS_IDLE);
        out_repeat      = (state_q == QS_FIRST) || (state_q == QS_SECOND);
        out_second      = (state_q == QS_SECOND);
        out_irq_block   = (state_q == QS_SECOND);
        out_illegal     = (state_q == QS_FAULT) && fault_q.illegal;
        out_align_fault = (state_q == QS_FAULT) && !fault_q.illegal && fault_q.misalign;
    end

    // R1: a taken first beat is followed by a second beat
    assert_first_then_second_R1: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_repeat && !out_second && !flush)
        |=> (out_valid && out_second));

    // R2: second beat is always part of a pair
    assert_second_has_repeat_R2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_second) |-> out_repeat);

    // R4: second beat address is the first beat address plus one doubleword
    assert_addr_step_R4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_repeat && !out_second && !flush)
        |=> (out_addr == $past(out_addr) + ADDR_W'(DW_BYTES)));

    // R5: a fault word is never part of a pair
    assert_fault_single_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && (out_align_fault || out_illegal)) |-> !out_repeat);

    // R6: at most one fault kind at a time
    assert_one_fault_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({out_align_fault, out_illegal}));

    // R7: interrupt block only on the second beat
    assert_irq_block_R7: assert property (@(posedge clk) disable iff (rst)
        out_irq_block |-> (out_valid && out_second));

    // R9: flush empties the block
    assert_flush_clears_R9: assert property (@(posedge clk) disable iff (rst)
        flush |=> (!out_valid && !stall_out));

    // R10: held output stays stable under back-pressure
    assert_hold_stable_R10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready && !flush)
        |=> (out_valid && stall_out && $stable(out_addr) && $stable(out_reg)
             && $stable(out_second)));
endmodule

// File: tb/qw_pair_seq_bench.sv
module qw_pair_seq_bench;
    localparam int ADDR_W = 16;
    localparam int REG_W  = 5;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              flush = 1'b0;
    logic              in_valid = 1'b0;
    logic [1:0]        in_kind = '0;
    logic [ADDR_W-1:0] in_addr = '0;
    logic [REG_W-1:0]  in_reg = '0;
    logic [REG_W-1:0]  in_ra = '0;
    logic [REG_W-1:0]  in_rb = '0;
    logic              in_le = 1'b0;
    logic              out_ready = 1'b0;
    logic              stall_out, out_valid, out_repeat, out_second;
    logic              out_align_fault, out_illegal, out_irq_block;
    logic [ADDR_W-1:0] out_addr;
    logic [REG_W-1:0]  out_reg;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    qw_pair_seq #(.ADDR_W(ADDR_W), .REG_W(REG_W), .DW_BYTES(8)) u_qw_pair_seq (
        .clk, .rst, .flush, .in_valid, .in_kind, .in_addr, .in_reg, .in_ra, .in_rb,
        .in_le, .stall_out, .out_valid, .out_ready, .out_addr, .out_reg, .out_repeat,
        .out_second, .out_align_fault, .out_illegal, .out_irq_block
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_req(input int kind, input int addr, input int tgt,
                           input int ra, input int rb, input int le, input int hold);
        bit ill, mis, flt;
        int r1, r2, a2;
        ill = (kind == 2) && (ra == tgt || rb == tgt);
        mis = ((kind == 2) || (kind == 0 && le == 1)) && ((addr & 15) != 0);
        flt = ill || mis;
        r1  = le ? (tgt | 1) : tgt;
        r2  = le ? tgt : (tgt | 1);
        a2  = (addr + 8) & 16'hFFFF;

        @(negedge clk);
        in_valid = 1'b1; in_kind = 2'(kind); in_addr = 16'(addr);
        in_reg = 5'(tgt); in_ra = 5'(ra); in_rb = 5'(rb); in_le = 1'(le);
        out_ready = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R1 first valid", int'(out_valid), 1);
        chk("R10 stall busy", int'(stall_out), 1);
        chk("R2 first repeat", int'(out_repeat), flt ? 0 : 1);
        chk("R2 first second", int'(out_second), 0);
        chk("R6 illegal", int'(out_illegal), int'(ill));
        chk("R5 align fault", int'(out_align_fault), int'(mis && !ill));
        chk("R7 irq first", int'(out_irq_block), 0);
        if (!flt) begin
            chk("R4 first addr", int'(out_addr), addr);
            chk("R3 first reg", int'(out_reg), r1);
        end
        for (int h = 0; h < hold; h++) begin
            in_valid = 1'b1; in_le = ~in_le; in_kind = 2'b01;
            in_addr = in_addr ^ 16'h0F0F; in_reg = in_reg ^ 5'h1E;
            @(negedge clk);
            chk("R10 hold valid", int'(out_valid), 1);
            chk("R10 hold stall", int'(stall_out), 1);
            if (!flt) chk("R10 hold addr", int'(out_addr), addr);
        end
        in_valid = 1'b0;
        out_ready = 1'b1;
        @(negedge clk);
        if (flt) begin
            chk("R5 single output", int'(out_valid), 0);
        end else begin
            in_le = ~in_le;
            chk("R1 second valid", int'(out_valid), 1);
            chk("R2 second flags", int'({out_repeat, out_second}), 3);
            chk("R4 second addr", int'(out_addr), a2);
            chk("R8 R3 second reg", int'(out_reg), r2);
            chk("R7 irq second", int'(out_irq_block), 1);
            @(negedge clk);
            chk("R1 idle after pair", int'(out_valid), 0);
            chk("R10 stall drops", int'(stall_out), 0);
        end
        out_ready = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R11 reset valid", int'(out_valid), 0);
        chk("R11 reset stall", int'(stall_out), 0);

        for (int k = 0; k < 4; k++)
            for (int le = 0; le < 2; le++)
                for (int lo = 0; lo < 16; lo++) begin
                    int tgt, ra, rb, addr;
                    tgt  = (k * 7 + lo * 3 + le * 11) % 32;
                    ra   = (lo == 5) ? tgt : tgt ^ 1;
                    rb   = (lo == 9) ? tgt : tgt ^ 2;
                    addr = (((k * 41 + le * 97 + lo * 13) & 12'hFFF) << 4) | lo;
                    if (lo == 15) addr = 16'hFFFF & (16'hFFF0 | 8);
                    run_req(k, addr, tgt, ra, rb, le, lo % 3);
                end

        // R9: flush on the first beat
        @(negedge clk);
        in_valid = 1'b1; in_kind = 2'b01; in_addr = 16'h1230; in_reg = 5'd6;
        in_le = 1'b1; out_ready = 1'b0;
        @(negedge clk);
        in_valid = 1'b0; flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        chk("R9 flush first valid", int'(out_valid), 0);
        chk("R9 flush first stall", int'(stall_out), 0);

        // R9: flush on the second beat
        in_valid = 1'b1; in_kind = 2'b00; in_addr = 16'h4560; in_le = 1'b0;
        @(negedge clk);
        in_valid = 1'b0; out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        chk("R7 before flush", int'(out_irq_block), 1);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        chk("R9 flush second valid", int'(out_valid), 0);
        chk("R9 flush irq", int'(out_irq_block), 0);
        @(negedge clk);
        chk("R9 stays idle", int'(out_valid), 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule